// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns a binary floating-point word into a fixed-width two's-complement or unsigned integer. A select input chooses signed or unsigned conversion. A two-bit mode input chooses the rounding mode, and a truncate input forces rounding toward zero whatever that mode says. Alongside the integer the block returns three flags:

- **invalid**: the value could not be represented or was not a number.
- **inexact**: a fractional part was discarded.
- **input subnormal**: the operand was subnormal.

Values outside the integer range saturate, and a NaN operand is handled by a fixed rule for each mode. The field widths of the floating-point word and the integer width are parameters; by default they are 8, 23 and 32.

The logic is a single combinational path followed by one output register. The integer and flags for an operand appear one clock after the operand is presented. A new operand can be accepted every cycle.

Top module: `f2i_convert`

## Requirements
- R1: An operand whose bits other than the sign (top bit) are all zero gives integer 0 with all three flags clear.
- R2: The subnormal flag is set exactly when the exponent field (the EXP_W bits below the sign) is zero and the fraction field (the low MAN_W bits) is nonzero.
- R3: A non-NaN operand with biased exponent of at least bias+INT_W raises invalid. Signed conversion then gives the largest positive value for a positive operand and the most negative value for a negative one. Unsigned conversion gives all ones for a positive operand and 0 for a negative one.
- R4: A NaN (exponent all ones, fraction nonzero) gives 0 with invalid in both signed and unsigned conversion.
- R5: For biased exponents from bias to bias+INT_W-1, the magnitude is the integer part plus one when rounding rounds up. The rounding modes are encoded as 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero. The directed modes round the magnitude up whenever any fraction remains and the mode points away from zero.
- R6: With truncate set, the result equals the one obtained in mode 3, whatever the mode input holds.
- R7: In unsigned conversion, a negative operand whose rounded magnitude is nonzero gives 0 with invalid.
- R8: In unsigned conversion, a round-up carry out of an all-ones integer part gives all ones with invalid. Inexact is also set when fraction was discarded.
- R9: In signed conversion, a rounded magnitude above 2^(INT_W-1)-1 for a positive operand, or above 2^(INT_W-1) for a negative one, is clamped to that limit and raises invalid. Negative results are returned in two's complement.
- R10: In range and not clamped, inexact is set exactly when a nonzero fraction was discarded.
- R11: A nonzero magnitude below one gives 0 with inexact in modes 0 and 3. In mode 1 a positive operand gives 1. In mode 2 a negative operand gives -1 when signed, and 0 with invalid when unsigned.
- R12: The outputs are registered: they are 0 with flags clear during reset, and they reflect the operand presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_in | input | 1+EXP_W+MAN_W | Floating-point operand: sign, biased exponent, fraction |
| to_signed | input | 1 | 1 = signed conversion, 0 = unsigned |
| rmode | input | 2 | Rounding mode (0 nearest-even, 1 up, 2 down, 3 toward zero) |
| trunc | input | 1 | Forces rounding toward zero |
| int_out | output | INT_W | Converted integer |
| invalid | output | 1 | Invalid conversion flag |
| inexact | output | 1 | Inexact result flag |
| denorm_in | output | 1 | Subnormal operand flag |

## Verification
The bench builds the block with a 4-bit exponent, a 5-bit fraction and a 4-bit integer. Every 10-bit operand is then swept under both signednesses, all four modes and both truncate settings.

At that size the widest in-range exponent leaves fraction bits below an integer part that can already be all ones. This brings the unsigned carry-into-saturation case and the signed clamp within reach. Ties at one half, subnormals, the below-one directed cases, infinities and every NaN are also covered. Expected values come from scaling the operand to an exact integer count of its smallest unit and rounding that arithmetically.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_UP      = 2'd1,
        RM_DOWN    = 2'd2,
        RM_ZERO    = 2'd3
    } f2i_rmode_e;

    typedef enum logic [1:0] {
        CLS_BELOW = 2'd0,
        CLS_RANGE = 2'd1,
        CLS_SAT   = 2'd2
    } f2i_class_e;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FP_W = 1 + EXP_W + MAN_W,
    localparam int SHW  = (INT_W > 1) ? $clog2(INT_W) : 1
) (
    input  logic [FP_W-1:0] fp_word,
    output logic            sign,
    output logic [MAN_W:0]  sig,
    output logic [SHW-1:0]  shamt,
    output f2i_class_e      cls,
    output logic            is_nan,
    output logic            is_zero,
    output logic            is_denorm
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
    localparam logic [EXP_W:0]   SAT_V  = (EXP_W + 1)'(BIAS + INT_W);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic [EXP_W-1:0] unb;

    always_comb begin
        exp_f     = fp_word[FP_W-2:MAN_W];
        man_f     = fp_word[MAN_W-1:0];
        sign      = fp_word[FP_W-1];
        sig       = {(exp_f != '0), man_f};
        is_nan    = (&exp_f) && (man_f != '0);
        is_zero   = (exp_f == '0) && (man_f == '0);
        is_denorm = (exp_f == '0) && (man_f != '0);
        unb       = exp_f - BIAS_V;
        shamt     = unb[SHW-1:0];
        if ({1'b0, exp_f} >= SAT_V)
            cls = CLS_SAT;
        else if (exp_f >= BIAS_V)
            cls = CLS_RANGE;
        else
            cls = CLS_BELOW;
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
#(
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int SHW   = (INT_W > 1) ? $clog2(INT_W) : 1,
    localparam int EXT_W = MAN_W + INT_W
) (
    input  logic [MAN_W:0]   sig,
    input  logic [SHW-1:0]   shamt,
    input  f2i_rmode_e       mode,
    input  logic             sign,
    output logic [INT_W-1:0] int_part,
    output logic             rem_nz,
    output logic             round_up
);
    logic [EXT_W-1:0] ext;
    logic [MAN_W-1:0] rem;
    logic             half;
    logic             sticky;

    always_comb begin
        ext      = EXT_W'(sig) << shamt;
        int_part = ext[EXT_W-1:MAN_W];
        rem      = ext[MAN_W-1:0];
        half     = rem[MAN_W-1];
        sticky   = |(rem << 1);
        rem_nz   = half | sticky;
        unique case (mode)
            RM_NEAREST: round_up = half & (sticky | int_part[0]);
            RM_UP:      round_up = ~sign & rem_nz;
            RM_DOWN:    round_up = sign & rem_nz;
            default:    round_up = 1'b0;
        endcase
    end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FP_W = 1 + EXP_W + MAN_W,
    localparam int SHW  = (INT_W > 1) ? $clog2(INT_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FP_W-1:0]  fp_in,
    input  logic             to_signed,
    input  logic [1:0]       rmode,
    input  logic             trunc,
    output logic [INT_W-1:0] int_out,
    output logic             invalid,
    output logic             inexact,
    output logic             denorm_in
);
    localparam logic [INT_W-1:0] ALL1_V = '1;
    localparam logic [INT_W-1:0] ONE_V  = INT_W'(1);
    localparam logic [INT_W-1:0] MAX_V  = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_V  = {1'b1, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
        logic             denorm;
    } conv_out_t;

    conv_out_t res_d, res_q;

    logic             u_sign, u_nan, u_zero, u_denorm;
    logic [MAN_W:0]   u_sig;
    logic [SHW-1:0]   u_shamt;
    f2i_class_e       u_cls;
    f2i_rmode_e       mode_eff;
    logic [INT_W-1:0] r_int;
    logic             r_rem_nz, r_up;

    logic [INT_W:0]   sum;
    logic [INT_W:0]   lim;
    logic [INT_W-1:0] mag;

    assign mode_eff = trunc ? RM_ZERO : f2i_rmode_e'(rmode);

    f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_unpack (
        .fp_word   (fp_in),
        .sign      (u_sign),
        .sig       (u_sig),
        .shamt     (u_shamt),
        .cls       (u_cls),
        .is_nan    (u_nan),
        .is_zero   (u_zero),
        .is_denorm (u_denorm)
    );

    f2i_round #(.MAN_W(MAN_W), .INT_W(INT_W)) u_round (
        .sig      (u_sig),
        .shamt    (u_shamt),
        .mode     (mode_eff),
        .sign     (u_sign),
        .int_part (r_int),
        .rem_nz   (r_rem_nz),
        .round_up (r_up)
    );

    always_comb begin
        res_d        = '0;
        res_d.denorm = u_denorm;
        sum          = {1'b0, r_int} + {{INT_W{1'b0}}, r_up};
        lim          = {1'b0, MAX_V} + {{INT_W{1'b0}}, u_sign};
        mag          = '0;
        if (u_nan) begin
            res_d.invalid = 1'b1;
        end else begin
            unique case (u_cls)
                CLS_SAT: begin
                    res_d.invalid = 1'b1;
                    if (to_signed)
                        res_d.value = u_sign ? MIN_V : MAX_V;
                    else
                        res_d.value = u_sign ? '0 : ALL1_V;
                end
                CLS_RANGE: begin
                    if (!to_signed) begin
                        if (sum[INT_W]) begin
                            mag           = ALL1_V;
                            res_d.invalid = 1'b1;
                        end else begin
                            mag = sum[INT_W-1:0];
                        end
                        if (u_sign && (mag != '0)) begin
                            res_d.value   = '0;
                            res_d.invalid = 1'b1;
                        end else begin
                            res_d.value   = mag;
                            res_d.inexact = r_rem_nz;
                        end
                    end else begin
                        if (sum > lim) begin
                            mag           = lim[INT_W-1:0];
                            res_d.invalid = 1'b1;
                        end else begin
                            mag           = sum[INT_W-1:0];
                            res_d.inexact = r_rem_nz;
                        end
                        res_d.value = u_sign ? (~mag + ONE_V) : mag;
                    end
                end
                default: begin
                    if (!u_zero) begin
                        res_d.inexact = 1'b1;
                        if (mode_eff == RM_UP && !u_sign) begin
                            res_d.value = ONE_V;
                        end else if (mode_eff == RM_DOWN && u_sign) begin
                            if (to_signed)
                                res_d.value = ALL1_V;
                            else
                                res_d.invalid = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign int_out   = res_q.value;
    assign invalid   = res_q.invalid;
    assign inexact   = res_q.inexact;
    assign denorm_in = res_q.denorm;
endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FP_W = 1 + EXP_W + MAN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FP_W-1:0]  fp_in,
    input logic             to_signed,
    input logic [INT_W-1:0] int_out,
    input logic             invalid,
    input logic             inexact,
    input logic             denorm_in
);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SAT_E = BIAS + INT_W;

    logic             primed_q;
    logic [EXP_W-1:0] c_exp;
    logic [MAN_W-1:0] c_man;
    logic             c_sign, c_nan, c_sat;

    assign c_exp  = fp_in[FP_W-2:MAN_W];
    assign c_man  = fp_in[MAN_W-1:0];
    assign c_sign = fp_in[FP_W-1];
    assign c_nan  = (&c_exp) && (c_man != '0);
    assign c_sat  = (int'(c_exp) >= SAT_E) && !c_nan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R1
    a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(fp_in[FP_W-2:0] == '0)
        |-> (int_out == '0) && !invalid && !inexact && !denorm_in);

    // R2
    a_r2_denorm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (denorm_in == $past((c_exp == '0) && (c_man != '0))));

    // R3
    a_r3_sat_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(c_sat) |-> invalid);

    // R4
    a_r4_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(c_nan) |-> (int_out == '0) && invalid);

    // R7
    a_r7_unsigned_neg: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(!to_signed && c_sign) |-> (int_out == '0));

    // R9
    a_r9_signed_pos_cap: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(to_signed && !c_sign && !c_nan) |-> !int_out[INT_W-1]);
endmodule

bind f2i_convert f2i_convert_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fp_in     (fp_in),
    .to_signed (to_signed),
    .int_out   (int_out),
    .invalid   (invalid),
    .inexact   (inexact),
    .denorm_in (denorm_in)
);

// File: tb/f2i_convert_tb.sv
module f2i_convert_tb;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 4;
    localparam int MW = 5;
    localparam int IW = 4;
    localparam int FW = 1 + EW + MW;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int FRB = BIAS + MW - 1;
    localparam int WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] fp_in = '0;
    logic          to_signed = 1'b0;
    logic [1:0]    rmode = 2'd0;
    logic          trunc = 1'b0;
    logic [IW-1:0] int_out;
    logic          invalid, inexact, denorm_in;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    f2i_convert #(.EXP_W(EW), .MAN_W(MW), .INT_W(IW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_in     (fp_in),
        .to_signed (to_signed),
        .rmode     (rmode),
        .trunc     (trunc),
        .int_out   (int_out),
        .invalid   (invalid),
        .inexact   (inexact),
        .denorm_in (denorm_in)
    );

    // {value, invalid, inexact, denorm}
    function automatic logic [IW+2:0] model(int w, int sg, int md);
        int s, e, m, res, inv, inx, den, v, tr, fr, up, mg, lm;
        s = (w >> (FW - 1)) & 1;
        e = (w >> MW) & ((1 << EW) - 1);
        m = w & ((1 << MW) - 1);
        res = 0; inv = 0; inx = 0;
        den = (e == 0 && m != 0) ? 1 : 0;
        if (e == (1 << EW) - 1 && m != 0) begin
            inv = 1;
        end else if (e >= BIAS + IW) begin
            inv = 1;
            if (sg != 0) res = s ? (1 << (IW - 1)) : (1 << (IW - 1)) - 1;
            else         res = s ? 0 : (1 << IW) - 1;
        end else if (e < BIAS) begin
            if (e != 0 || m != 0) begin
                inx = 1;
                if (md == 1 && s == 0) res = 1;
                else if (md == 2 && s == 1) begin
                    if (sg != 0) res = (1 << IW) - 1;
                    else         inv = 1;
                end
            end
        end else begin
            v  = ((1 << MW) + m) << (e - 1);
            tr = v >> FRB;
            fr = v & ((1 << FRB) - 1);
            case (md)
                0: up = (fr > (1 << (FRB - 1)) || (fr == (1 << (FRB - 1)) && (tr & 1) == 1)) ? 1 : 0;
                1: up = (s == 0 && fr != 0) ? 1 : 0;
                2: up = (s == 1 && fr != 0) ? 1 : 0;
                default: up = 0;
            endcase
            mg = tr + up;
            if (sg == 0) begin
                if (mg > (1 << IW) - 1) begin mg = (1 << IW) - 1; inv = 1; end
                if (s == 1 && mg != 0) begin res = 0; inv = 1; end
                else begin res = mg; inx = (fr != 0) ? 1 : 0; end
            end else begin
                lm = (1 << (IW - 1)) - 1 + s;
                if (mg > lm) begin mg = lm; inv = 1; end
                else inx = (fr != 0) ? 1 : 0;
                res = s ? (((1 << IW) - mg) & ((1 << IW) - 1)) : mg;
            end
        end
        return {IW'(res), inv[0], inx[0], den[0]};
    endfunction

    function automatic string tag_of(int w, int sg, int t);
        int s, e, m;
        s = (w >> (FW - 1)) & 1;
        e = (w >> MW) & ((1 << EW) - 1);
        m = w & ((1 << MW) - 1);
        if (e == (1 << EW) - 1 && m != 0) return "R4";
        if (e >= BIAS + IW) return "R3";
        if (e == 0 && m == 0) return "R1";
        if (e == 0) return "R2";
        if (e < BIAS) return "R11";
        if (t != 0) return "R6";
        if (sg == 0 && s == 1) return "R7";
        if (sg == 0 && e == BIAS + IW - 1) return "R8";
        if (sg != 0 && e == BIAS + IW - 1) return "R9";
        if (m != 0) return "R10";
        return "R5";
    endfunction

    task automatic check(string tag, logic [IW+2:0] got, logic [IW+2:0] exp_v, int w);
        checks++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s operand=%h got=%h expected=%h", tag, w[FW-1:0], got, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired got=%0d expected<%0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        fp_in = FW'(10'h1AB);
        to_signed = 1'b1;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {int_out, invalid, inexact, denorm_in}, '0, 0);
        rst_n = 1'b1;
        for (int w = 0; w < (1 << FW); w++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int md = 0; md < 4; md++) begin
                    for (int t = 0; t < 2; t++) begin
                        fp_in     = FW'(w);
                        to_signed = sg[0];
                        rmode     = md[1:0];
                        trunc     = t[0];
                        @(negedge clk);
                        check(tag_of(w, sg, t), {int_out, invalid, inexact, denorm_in},
                              model(w, sg, (t != 0) ? 3 : md), w);
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule